// File: doc/BRIEF.md
# Dual-Context Level Interrupt Controller with Shadow Masking

This block gathers a set of level-sensitive interrupt lines, gates each one with its own enable bit, and drives one interrupt request per processor context. There are two contexts. An ordinary source goes to exactly one context, chosen by a compile-time routing vector. A per-context source can reach both contexts. To give the second context a separate mask for such a source, a compile-time table pairs it with a spare source number, its "shadow". The shadow's enable bit then masks only the second context's view of the paired source. The shadow's own input pin is never looked at.

Software sees four 32-bit registers on a simple register bus. Two registers hold the enable bits: the low bank covers sources 0 to 31 and the high bank covers sources 32 and up. Two read-only registers report the masked pending state. Pending is computed combinationally from the live input level, so it is never latched. The request outputs and read data are registered.

Top module: `dual_ctx_intc`

## Requirements
- R1: There are 40 sources. Enable bit n of the register at byte offset 0x04 gates source n for n in 0..31. A write replaces all 32 bits, and a read returns exactly the last written value.
- R2: Enable bits for sources 32..39 sit in bits 7:0 of the register at offset 0x50. Bit n-32 controls source n. Bits 31:8 of that register ignore writes and read 0.
- R3: Reading offset 0x08 returns the pending bits of sources 0..31. Reading offset 0x54 returns the pending bits of sources 32..39 in bits 7:0, with bits 31:8 at 0. A pending bit is the current input level ANDed with its enable bit and is not held once the level drops.
- R4: After synchronous reset, every enable bit is 0, both request outputs are 0 and read data is 0.
- R5: An ordinary source reaches only one context. With the default routing, sources 8..15, 34 and 35 go to context 1, and every other ordinary source goes to context 0.
- R6: For each per-context pair (target T, shadow S), context 0 sees T gated by T's enable bit and context 1 sees T gated by S's enable bit. The default pairs are (T=30, S=29) and (T=39, S=33).
- R7: A shadow's input line has no effect on any output. The shadow's pending bit reports T's level ANDed with S's enable bit.
- R8: Each request output is the OR of all enabled sources routed to its context. It is registered, so it changes one clock after the inputs or enables change.
- R9: Writes to the pending registers or to unmapped offsets change no enable bit. Reads of unmapped offsets return 0.
- R10: Read data appears on the clock edge that samples the read strobe and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 40 | Level interrupt inputs, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Registered interrupt request, one bit per context |

## Verification
Random source levels and random enable words are applied together, and each request output and both pending registers are compared against a bench model. This tells apart mistakes in routing, masking and bank splitting. Directed cases handle each pair's two masks separately: target enabled with shadow masked, and the reverse. That shows whether the context-1 view really follows the shadow bit. A lone active shadow input checks that the shadow pin is ignored. Dropping a level checks that pending does not latch. Sampling the request before and after one clock edge checks the single register stage.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t OFS_EN_LO = 8'h04;
  localparam addr_t OFS_PD_LO = 8'h08;
  localparam addr_t OFS_EN_HI = 8'h50;
  localparam addr_t OFS_PD_HI = 8'h54;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  addr_t              addr_i,
  input  word_t              wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] en_o,
  output word_t              rdata_o
);
  localparam int HI_W = NUM_SRC - DATA_W;

  word_t            en_lo;
  logic [HI_W-1:0]  en_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_lo <= '0;
      en_hi <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_EN_LO) en_lo <= wdata_i;
      if (addr_i == OFS_EN_HI) en_hi <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        OFS_EN_LO: rdata_o <= en_lo;
        OFS_EN_HI: rdata_o <= DATA_W'(en_hi);
        OFS_PD_LO: rdata_o <= pend_i[DATA_W-1:0];
        OFS_PD_HI: rdata_o <= DATA_W'(pend_i[NUM_SRC-1:DATA_W]);
        default:   rdata_o <= '0;
      endcase
    end
  end

  assign en_o = {en_hi, en_lo};

  AST_EN_RESET: assert property (@(posedge clk) $fell(rst) |-> (en_lo == '0 && en_hi == '0)); // R4
  AST_WR_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_EN_LO) |=> (en_o[DATA_W-1:0] == $past(wdata_i))); // R1
  AST_HI_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (addr_i == OFS_EN_HI || addr_i == OFS_PD_HI)) |=> (rdata_o[DATA_W-1:HI_W] == '0)); // R2
  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i != OFS_EN_LO && addr_i != OFS_EN_HI) |=> $stable(en_o)); // R9
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int                       NUM_SRC     = 40,
  parameter int                       NUM_PAIRS   = 2,
  parameter logic [NUM_SRC-1:0]       ROUTE_CTX1  = 40'h0C_0000_FF00,
  parameter logic [NUM_PAIRS*8-1:0]   PAIR_TARGET = {8'd39, 8'd30},
  parameter logic [NUM_PAIRS*8-1:0]   PAIR_SHADOW = {8'd33, 8'd29}
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] view0_o,
  output logic [NUM_SRC-1:0] view1_o
);
  localparam int IDXW = $clog2(NUM_SRC);

  logic [IDXW-1:0] tgt_idx [NUM_PAIRS];
  logic [IDXW-1:0] shd_idx [NUM_PAIRS];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign tgt_idx[p] = PAIR_TARGET[p*8 +: IDXW];
    assign shd_idx[p] = PAIR_SHADOW[p*8 +: IDXW];
  end

  always_comb begin
    pend_o  = src_i & en_i;
    view0_o = pend_o & ~ROUTE_CTX1;
    view1_o = pend_o & ROUTE_CTX1;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      pend_o[shd_idx[p]]  = src_i[tgt_idx[p]] & en_i[shd_idx[p]];
      view0_o[shd_idx[p]] = 1'b0;
      view1_o[shd_idx[p]] = pend_o[shd_idx[p]];
      view0_o[tgt_idx[p]] = pend_o[tgt_idx[p]];
      view1_o[tgt_idx[p]] = 1'b0;
    end
  end
endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] view_i [NUM_CTX],
  output logic [NUM_CTX-1:0] irq_o
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (rst) irq_o[c] <= 1'b0;
      else     irq_o[c] <= |view_i[c];
    end
    AST_IRQ_REG: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq_o[c] == $past(|view_i[c]))); // R8
  end
endmodule

// File: rtl/dual_ctx_intc.sv
module dual_ctx_intc
  import intc_pkg::*;
#(
  parameter int                     NUM_SRC     = 40,
  parameter int                     NUM_PAIRS   = 2,
  parameter logic [NUM_SRC-1:0]     ROUTE_CTX1  = 40'h0C_0000_FF00,
  parameter logic [NUM_PAIRS*8-1:0] PAIR_TARGET = {8'd39, 8'd30},
  parameter logic [NUM_PAIRS*8-1:0] PAIR_SHADOW = {8'd33, 8'd29}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [1:0]         irq_o
);
  localparam int NUM_CTX = 2;

  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] views [NUM_CTX];

  intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pend_i(pend),
    .en_o(en), .rdata_o(rdata_o)
  );

  intc_route #(
    .NUM_SRC(NUM_SRC), .NUM_PAIRS(NUM_PAIRS), .ROUTE_CTX1(ROUTE_CTX1),
    .PAIR_TARGET(PAIR_TARGET), .PAIR_SHADOW(PAIR_SHADOW)
  ) u_route (
    .src_i(src_i), .en_i(en), .pend_o(pend),
    .view0_o(views[0]), .view1_o(views[1])
  );

  intc_irq_out #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_irq (
    .clk(clk), .rst(rst), .view_i(views), .irq_o(irq_o)
  );

  AST_PEND_IN_EN: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~en) == '0)); // R3
  AST_CTX_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((views[0] & views[1]) == '0)); // R5
endmodule

// File: tb/dual_ctx_intc_tb.sv
module dual_ctx_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0, n_bad = 0;
  logic [39:0] m_en = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_ctx_intc u_dut (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [39:0] CTX1_SET = 40'h0C_0000_FF00;

  function automatic logic [39:0] m_pend(logic [39:0] s, logic [39:0] e);
    logic [39:0] p = s & e;
    p[29] = s[30] & e[29];
    p[33] = s[39] & e[33];
    return p;
  endfunction

  function automatic logic [1:0] m_irq(logic [39:0] s, logic [39:0] e);
    logic [39:0] p = m_pend(s, e);
    logic [39:0] v0 = p & ~CTX1_SET;
    logic [39:0] v1 = p & CTX1_SET;
    v0[29] = 1'b0; v0[33] = 1'b0; v0[30] = p[30]; v0[39] = p[39];
    v1[29] = p[29]; v1[33] = p[33]; v1[30] = 1'b0; v1[39] = 1'b0;
    return {|v1, |v0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    if (a == 8'h04) m_en[31:0] = d;
    if (a == 8'h50) m_en[39:32] = d[7:0];
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    logic [39:0] p;
    step();
    check({req, " irq"}, 32'(irq), 32'(m_irq(src, m_en)));
    p = m_pend(src, m_en);
    rd(8'h08, d); check({req, " pend_lo"}, d, p[31:0]);
    rd(8'h54, d); check({req, " pend_hi"}, d, 32'(p[39:32]));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    #1;
    step(); step(); step();
    // R4: reset state
    check("R4 irq", 32'(irq), 32'h0);
    check("R4 rdata", rdata, 32'h0);
    rst = 1'b0;
    src = '1;
    step();
    check("R4 irq masked", 32'(irq), 32'h0);
    rd(8'h04, d); check("R4 en_lo", d, 32'h0);
    rd(8'h50, d); check("R4 en_hi", d, 32'h0);

    // R1 readback, R10 hold
    wr(8'h04, 32'hA5C3_0F81);
    rd(8'h04, d); check("R1 en_lo readback", d, 32'hA5C3_0F81);
    step(); check("R10 rdata holds", rdata, 32'hA5C3_0F81);
    // R2 upper bits ignored
    wr(8'h50, 32'hFFFF_FF5A);
    rd(8'h50, d); check("R2 en_hi upper zero", d, 32'h0000_005A);
    // R9 ignored writes, unmapped reads
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R9 en_lo unchanged", d, 32'hA5C3_0F81);
    rd(8'h50, d); check("R9 en_hi unchanged", d, 32'h0000_005A);
    rd(8'h10, d); check("R9 unmapped read", d, 32'h0);
    rd(8'h00, d); check("R9 unmapped read 0", d, 32'h0);

    // R5 routing: only source 9 (ctx1) then only source 2 (ctx0)
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h50, 32'hFF);
    src = 40'h0; src[9] = 1'b1;
    step(); check("R5 src9 to ctx1", 32'(irq), 32'h2);
    src = 40'h0; src[2] = 1'b1;
    step(); check("R5 src2 to ctx0", 32'(irq), 32'h1);
    src = 40'h0; src[35] = 1'b1;
    step(); check("R5 src35 to ctx1", 32'(irq), 32'h2);

    // R6 pair (30,29): target enabled, shadow masked, then reverse
    src = 40'h0; src[30] = 1'b1;
    wr(8'h04, 32'h4000_0000);
    step(); check("R6 T30 ctx0 only", 32'(irq), 32'h1);
    wr(8'h04, 32'h2000_0000);
    step(); check("R6 S29 ctx1 only", 32'(irq), 32'h2);
    rd(8'h08, d); check("R7 shadow pend reports target", d, 32'h2000_0000);
    // R6 pair (39,33)
    wr(8'h04, 32'h0); src = 40'h0; src[39] = 1'b1;
    wr(8'h50, 32'h02);
    step(); check("R6 S33 ctx1 only", 32'(irq), 32'h2);
    wr(8'h50, 32'h80);
    step(); check("R6 T39 ctx0 only", 32'(irq), 32'h1);
    // R7 shadow input ignored
    wr(8'h50, 32'h02); wr(8'h04, 32'h2000_0000);
    src = 40'h0; src[29] = 1'b1; src[33] = 1'b1;
    step(); check("R7 shadow pins ignored irq", 32'(irq), 32'h0);
    rd(8'h08, d); check("R7 shadow pend lo", d, 32'h0);
    rd(8'h54, d); check("R7 shadow pend hi", d, 32'h0);

    // R3 no latching
    wr(8'h04, 32'h0000_0010); src = 40'h0; src[4] = 1'b1;
    rd(8'h08, d); check("R3 pend set", d, 32'h0000_0010);
    src[4] = 1'b0;
    rd(8'h08, d); check("R3 pend drops", d, 32'h0);

    // R8 registered: before edge old value, after edge new
    step();
    src[4] = 1'b1; #1;
    check("R8 irq before edge", 32'(irq), 32'h0);
    step(); check("R8 irq after edge", 32'(irq), 32'h1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: wr(8'h04, $urandom);
        1: wr(8'h50, $urandom);
        2: wr(8'(($urandom_range(0, 31)) * 4), $urandom);
        default: ;
      endcase
      src = {8'($urandom), 32'($urandom)} & {8'($urandom), 32'($urandom)};
      check_all("R3 R5 R6 R8 random");
      if (i % 16 == 0) begin
        rd(8'h04, d); check("R1 random en_lo", d, m_en[31:0]);
        rd(8'h50, d); check("R2 random en_hi", d, 32'(m_en[39:32]));
      end
    end

    done = 1;
    report();
    $finish;
  end
endmodule